// File: doc/BRIEF.md
# Over-Current Pulse-Skip and Latch-Off Handler

This block guards one channel of a synchronous buck controller against over-current. On each low-side on-time it holds a digitised current sample, taken a programmed number of clock ticks after the low-side switch turns on. It compares the held sample against a limit code. The comparison result is acted on only when the switching-cycle start strobe arrives.

A hit in normal operation inhibits the high-side drive for a fixed window of switching cycles. A probation window of the same length follows. A second hit at any cycle start inside probation latches the channel off: both drivers stay inhibited and power-good is pulled low. Only a low pulse on enable clears the latch. If probation ends with no hit, the handler returns to normal operation by itself.

Switching-cycle numbering used below: the cycle that begins at the strobe where the first hit is acted on is cycle 1. The skip window is cycles 1 to 8 and probation is cycles 9 to 16, with the default window lengths.

Top module: `ocp_guard`

## Requirements
- R1: After reset with enable high, hs_inhibit, ls_inhibit, oc_fault and pg_pulldown are all 0.
- R2: The sample is the isense value present at the SAMPLE_DLY-th rising clock edge at which lo_on is high, counted from the start of the on-time. Values present earlier in the on-time have no effect on the decision.
- R3: A hit is a held sample greater than or equal to ilim, and a sample equal to ilim counts as a hit. A sample from one switching cycle is judged at the next cyc_start strobe. No strobe is judged as a hit before the first sample taken since reset or enable.
- R4: In normal operation, a hit at a strobe raises hs_inhibit at that clock edge. hs_inhibit then stays high for exactly SKIP_LEN switching cycles (8), and hits at strobes inside the skip window before its last strobe are ignored.
- R5: A hit at the strobe that starts any of cycles 9 to 16 sets the latch. oc_fault, hs_inhibit, ls_inhibit and pg_pulldown are then all 1, and ls_inhibit is 0 at all other times while enable is high.
- R6: Without a hit at the strobes starting cycles 9 to 16, the handler returns to normal operation. A hit at the strobe starting cycle 17 opens a new skip window instead of latching.
- R7: The latch holds whatever current is sampled while enable stays high. While enable is low, oc_fault is 0, the held sample is discarded, and hs_inhibit, ls_inhibit and pg_pulldown are 1. Raising enable again resumes normal operation.
- R8: oc_fault only rises at a clock edge where cyc_start was high with a pending hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Channel enable; a low level clears a latched fault |
| cyc_start | input | 1 | One-clock strobe at the start of each switching cycle |
| lo_on | input | 1 | High while the low-side switch is on |
| isense | input | W | Digitised current reading |
| ilim | input | W | Current limit code |
| hs_inhibit | output | 1 | Blocks the high-side pulse |
| ls_inhibit | output | 1 | Blocks the low-side drive |
| oc_fault | output | 1 | Over-current latch is set |
| pg_pulldown | output | 1 | Pulls the power-good flag low |

## Verification
The cycle counter is the most likely place for a wrong internal state to hide, and it surfaces at the ports one switching cycle after the strobe where it matters. An off-by-one skip window shows as hs_inhibit staying high, or dropping, one switching cycle too early or too late. An off-by-one probation window shows either as a latch at the strobe that starts cycle 17, or as a missing latch at cycle 9 or 16. A wrong sample instant shows as a detection decided by an early-on-time current, visible as hs_inhibit one strobe later.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  typedef enum logic [1:0] {
    OC_NORMAL    = 2'd0,
    OC_SKIP      = 2'd1,
    OC_PROBATION = 2'd2,
    OC_LATCHED   = 2'd3
  } oc_state_t;

  // Limit comparison: reaching the limit counts as a hit.
  function automatic logic at_or_over(input logic [31:0] sample, input logic [31:0] limit);
    return sample >= limit;
  endfunction

  // Width needed to count up to and including n.
  function automatic int count_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/ocp_sampler.sv
module ocp_sampler #(
  parameter int W          = 8,
  parameter int SAMPLE_DLY = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         lo_on,
  input  logic [W-1:0] isense,
  input  logic [W-1:0] ilim,
  output logic         lim_det
);
  localparam int DW = ocp_pkg::count_width(SAMPLE_DLY);

  logic [DW-1:0] dly_q;
  logic          taken_q;
  logic          vld_q;
  logic [W-1:0]  held_q;
  logic          det_q;
  logic          capture;

  // Capture on the SAMPLE_DLY-th edge of the on-time.
  assign capture = lo_on && !taken_q && (dly_q == DW'(SAMPLE_DLY - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q   <= '0;
      taken_q <= 1'b0;
      vld_q   <= 1'b0;
      held_q  <= '0;
      det_q   <= 1'b0;
    end else if (!enable) begin
      dly_q   <= '0;
      taken_q <= 1'b0;
      vld_q   <= 1'b0;
      held_q  <= '0;
      det_q   <= 1'b0;
    end else begin
      if (!lo_on) begin
        dly_q   <= '0;
        taken_q <= 1'b0;
      end else if (!taken_q) begin
        dly_q <= dly_q + DW'(1);
        if (capture) begin
          taken_q <= 1'b1;
          vld_q   <= 1'b1;
          held_q  <= isense;
        end
      end
      det_q <= vld_q && ocp_pkg::at_or_over(32'(held_q), 32'(ilim));
    end
  end

  assign lim_det = det_q;

endmodule

// File: rtl/ocp_sequencer.sv
module ocp_sequencer
  import ocp_pkg::*;
#(
  parameter int SKIP_LEN  = 8,
  parameter int PROBE_LEN = 8,
  parameter int CW        = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          cyc_start,
  input  logic          lim_det,
  output oc_state_t     state,
  output logic [CW-1:0] win_cnt
);
  localparam logic [CW-1:0] SKIP_LAST  = CW'(SKIP_LEN);
  localparam logic [CW-1:0] PROBE_LAST = CW'(SKIP_LEN + PROBE_LEN);

  oc_state_t     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (cyc_start) begin
      unique case (st_q)
        OC_NORMAL: begin
          if (lim_det) begin
            st_d  = OC_SKIP;
            cnt_d = CW'(1);
          end
        end
        OC_SKIP: begin
          cnt_d = cnt_q + CW'(1);
          if (cnt_q == SKIP_LAST) begin
            st_d = lim_det ? OC_LATCHED : OC_PROBATION;
          end
        end
        OC_PROBATION: begin
          if (cnt_q == PROBE_LAST) begin
            st_d  = lim_det ? OC_SKIP : OC_NORMAL;
            cnt_d = lim_det ? CW'(1) : '0;
          end else if (lim_det) begin
            st_d = OC_LATCHED;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        OC_LATCHED: begin
          st_d = OC_LATCHED;
        end
        default: begin
          st_d  = OC_NORMAL;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= OC_NORMAL;
      cnt_q <= '0;
    end else if (!enable) begin
      st_q  <= OC_NORMAL;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state   = st_q;
  assign win_cnt = cnt_q;

endmodule

// File: rtl/ocp_drive.sv
module ocp_drive
  import ocp_pkg::*;
(
  input  logic      enable,
  input  oc_state_t state,
  output logic      hs_inhibit,
  output logic      ls_inhibit,
  output logic      oc_fault,
  output logic      pg_pulldown
);
  logic latched;
  logic skipping;

  assign latched     = enable && (state == OC_LATCHED);
  assign skipping    = enable && (state == OC_SKIP);
  assign oc_fault    = latched;
  assign hs_inhibit  = !enable || skipping || latched;
  assign ls_inhibit  = !enable || latched;
  assign pg_pulldown = !enable || latched;

endmodule

// File: rtl/ocp_guard.sv
module ocp_guard
  import ocp_pkg::*;
#(
  parameter int W          = 8,
  parameter int SAMPLE_DLY = 40,
  parameter int SKIP_LEN   = 8,
  parameter int PROBE_LEN  = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         cyc_start,
  input  logic         lo_on,
  input  logic [W-1:0] isense,
  input  logic [W-1:0] ilim,
  output logic         hs_inhibit,
  output logic         ls_inhibit,
  output logic         oc_fault,
  output logic         pg_pulldown
);
  localparam int CW = count_width(SKIP_LEN + PROBE_LEN);

  // Named internal events, brought out for the checker.
  logic          lim_det;
  logic          strobe_hit;
  oc_state_t     state;
  logic [CW-1:0] win_cnt;

  assign strobe_hit = cyc_start && lim_det;

  ocp_sampler #(
    .W          (W),
    .SAMPLE_DLY (SAMPLE_DLY)
  ) u_sampler (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .lo_on   (lo_on),
    .isense  (isense),
    .ilim    (ilim),
    .lim_det (lim_det)
  );

  ocp_sequencer #(
    .SKIP_LEN  (SKIP_LEN),
    .PROBE_LEN (PROBE_LEN),
    .CW        (CW)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .cyc_start (cyc_start),
    .lim_det   (lim_det),
    .state     (state),
    .win_cnt   (win_cnt)
  );

  ocp_drive u_drive (
    .enable      (enable),
    .state       (state),
    .hs_inhibit  (hs_inhibit),
    .ls_inhibit  (ls_inhibit),
    .oc_fault    (oc_fault),
    .pg_pulldown (pg_pulldown)
  );

endmodule

// File: rtl/ocp_guard_chk.sv
module ocp_guard_chk #(
  parameter int SKIP_LEN = 8
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic cyc_start,
  input logic strobe_hit,
  input logic hs_inhibit,
  input logic ls_inhibit,
  input logic oc_fault,
  input logic pg_pulldown
);
  localparam int KW = $clog2(SKIP_LEN + 2) + 1;

  // Strobes seen while the high side is held off by a skip window.
  logic [KW-1:0] skip_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skip_seen <= '0;
    end else if (!enable || !hs_inhibit || oc_fault) begin
      skip_seen <= '0;
    end else if (cyc_start) begin
      skip_seen <= skip_seen + KW'(1);
    end
  end

  a_r4_skip_window_len: assert property (@(posedge clk) disable iff (!rst_n)
    skip_seen <= KW'(SKIP_LEN));

  a_r4_inhibit_starts_at_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $rose(hs_inhibit)) |-> $past(strobe_hit));

  a_r5_latch_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    oc_fault |-> (hs_inhibit && ls_inhibit && pg_pulldown));

  a_r7_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_fault && enable) |=> (oc_fault || !enable));

  a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!oc_fault && hs_inhibit && ls_inhibit && pg_pulldown));

  a_r8_fault_at_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oc_fault) |-> $past(strobe_hit));

endmodule

bind ocp_guard ocp_guard_chk #(
  .SKIP_LEN (SKIP_LEN)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .cyc_start   (cyc_start),
  .strobe_hit  (strobe_hit),
  .hs_inhibit  (hs_inhibit),
  .ls_inhibit  (ls_inhibit),
  .oc_fault    (oc_fault),
  .pg_pulldown (pg_pulldown)
);

// File: tb/tb_ocp_guard.sv
module tb_ocp_guard;
  localparam int CLK_PERIOD = 10;
  localparam int CYC        = 16;   // clocks per switching cycle
  localparam int DLY        = 4;    // sample delay used on the bench
  localparam int LO_START   = 4;
  localparam int LO_END     = 14;
  localparam logic [7:0] LIMIT = 8'd100;

  // Row: {current, expected hs_inhibit, expected fault}; the row's current is
  // judged at the next row's strobe.
  localparam int NROW = 31;
  localparam logic [9:0] TBL [NROW] = '{
    {8'd50, 1'b0, 1'b0}, {8'd120,1'b0, 1'b0}, {8'd50, 1'b1, 1'b0}, {8'd50, 1'b1, 1'b0},
    {8'd50, 1'b1, 1'b0}, {8'd150,1'b1, 1'b0}, {8'd50, 1'b1, 1'b0}, {8'd50, 1'b1, 1'b0},
    {8'd50, 1'b1, 1'b0}, {8'd50, 1'b1, 1'b0}, {8'd50, 1'b0, 1'b0}, {8'd50, 1'b0, 1'b0},
    {8'd50, 1'b0, 1'b0}, {8'd50, 1'b0, 1'b0}, {8'd50, 1'b0, 1'b0}, {8'd50, 1'b0, 1'b0},
    {8'd50, 1'b0, 1'b0}, {8'd50, 1'b0, 1'b0}, {8'd120,1'b0, 1'b0}, {8'd50, 1'b1, 1'b0},
    {8'd50, 1'b1, 1'b0}, {8'd50, 1'b1, 1'b0}, {8'd50, 1'b1, 1'b0}, {8'd50, 1'b1, 1'b0},
    {8'd50, 1'b1, 1'b0}, {8'd50, 1'b1, 1'b0}, {8'd50, 1'b1, 1'b0}, {8'd50, 1'b0, 1'b0},
    {8'd120,1'b0, 1'b0}, {8'd50, 1'b1, 1'b1}, {8'd50, 1'b1, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b1;
  logic       cyc_start = 1'b0;
  logic       lo_on = 1'b0;
  logic [7:0] isense = 8'd0;
  logic [7:0] ilim = LIMIT;
  logic       hs_inhibit, ls_inhibit, oc_fault, pg_pulldown;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ocp_guard #(
    .W          (8),
    .SAMPLE_DLY (DLY),
    .SKIP_LEN   (8),
    .PROBE_LEN  (8)
  ) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .cyc_start   (cyc_start),
    .lo_on       (lo_on),
    .isense      (isense),
    .ilim        (ilim),
    .hs_inhibit  (hs_inhibit),
    .ls_inhibit  (ls_inhibit),
    .oc_fault    (oc_fault),
    .pg_pulldown (pg_pulldown)
  );

  task automatic check_out(input logic e_hs, input logic e_ls, input logic e_flt,
                           input logic e_pg, input string tag);
    checks++;
    if ({hs_inhibit, ls_inhibit, oc_fault, pg_pulldown} !== {e_hs, e_ls, e_flt, e_pg}) begin
      errors++;
      $display("FAIL %s: hs/ls/fault/pg actual=%b%b%b%b expected=%b%b%b%b", tag,
               hs_inhibit, ls_inhibit, oc_fault, pg_pulldown, e_hs, e_ls, e_flt, e_pg);
    end
  endtask

  // One switching cycle. The sample lands on the clock edge after tick
  // LO_START+DLY-1; 'early' is driven before that tick, 'cur' from it on.
  // Outputs are checked at tick 2, after the strobe edge.
  task automatic do_cycle(input logic [7:0] early, input logic [7:0] cur,
                          input logic e_hs, input logic e_ls, input logic e_flt,
                          input logic e_pg, input string tag);
    for (int t = 0; t < CYC; t++) begin
      @(negedge clk);
      cyc_start = (t == 0);
      lo_on     = (t >= LO_START) && (t < LO_END);
      isense    = (t < LO_START + DLY - 1) ? early : cur;
      if (t == 2) check_out(e_hs, e_ls, e_flt, e_pg, tag);
    end
  endtask

  task automatic pulse_enable_low(input string tag);
    @(negedge clk);
    enable = 1'b0;
    do_cycle(8'd150, 8'd150, 1'b1, 1'b1, 1'b0, 1'b1, tag);
    @(negedge clk);
    enable = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state with enable high
    check_out(1'b0, 1'b0, 1'b0, 1'b0, "R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_out(1'b0, 1'b0, 1'b0, 1'b0, "R1 after reset");

    // Table: skip, probation expiry, recurrence and latch (R4 R5 R6 R3)
    for (int i = 0; i < NROW; i++) begin
      do_cycle(TBL[i][9:2], TBL[i][9:2], TBL[i][1], TBL[i][0], TBL[i][0], TBL[i][0],
               $sformatf("R4/R5/R6 table row %0d", i));
    end

    // R7: latch survives low currents, then enable low clears it
    do_cycle(8'd10, 8'd10, 1'b1, 1'b1, 1'b1, 1'b1, "R7 latch holds");
    pulse_enable_low("R7 enable low");

    // R3: equality is a hit; stale sample discarded by enable low (R7)
    do_cycle(8'd100, 8'd100, 1'b0, 1'b0, 1'b0, 1'b0, "R7 resumed no stale hit");
    do_cycle(8'd50, 8'd50, 1'b1, 1'b0, 1'b0, 1'b0, "R3 equal to limit hits");
    for (int i = 2; i <= 7; i++)
      do_cycle(8'd50, 8'd50, 1'b1, 1'b0, 1'b0, 1'b0, "R4 skip");
    do_cycle(8'd120, 8'd120, 1'b1, 1'b0, 1'b0, 1'b0, "R4 skip cycle 8");
    // R5: hit at the strobe starting cycle 9
    do_cycle(8'd50, 8'd50, 1'b1, 1'b1, 1'b1, 1'b1, "R5 latch at cycle 9");
    pulse_enable_low("R7 enable low again");

    // R6: hit at the strobe starting cycle 17 opens a new skip window
    do_cycle(8'd120, 8'd120, 1'b0, 1'b0, 1'b0, 1'b0, "R6 trigger");
    for (int i = 1; i <= 8; i++)
      do_cycle(8'd50, 8'd50, 1'b1, 1'b0, 1'b0, 1'b0, "R6 skip");
    for (int i = 9; i <= 15; i++)
      do_cycle(8'd50, 8'd50, 1'b0, 1'b0, 1'b0, 1'b0, "R6 probation");
    do_cycle(8'd120, 8'd120, 1'b0, 1'b0, 1'b0, 1'b0, "R6 probation cycle 16");
    do_cycle(8'd50, 8'd50, 1'b1, 1'b0, 1'b0, 1'b0, "R6 cycle 17 reskips");
    do_cycle(8'd50, 8'd50, 1'b1, 1'b0, 1'b0, 1'b0, "R6 still skipping");
    pulse_enable_low("R7 enable low third");

    // R2: only the value at the sample instant counts
    do_cycle(8'd150, 8'd50, 1'b0, 1'b0, 1'b0, 1'b0, "R2 setup");
    do_cycle(8'd50, 8'd150, 1'b0, 1'b0, 1'b0, 1'b0, "R2 early high ignored");
    do_cycle(8'd50, 8'd50, 1'b1, 1'b0, 1'b0, 1'b0, "R2 late high detected");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule